// File: doc/BRIEF.md
# Status-Register Interrupt Gate with Non-Maskable Top Level

This block decides whether a pending interrupt is accepted. Each clock it compares an encoded request level against the interrupt mask held in the status register. It also holds the status-register fields that take part in that decision: a 3-bit mask and a master/interrupt-state bit. Every other bit of the register reads back as zero.

Levels 1 to 6 are level-sensitive and maskable. A request is accepted only when its level is strictly above the current mask. The top level, 7, ignores the mask. It is edge-sensitive and is accepted once each time the request moves into 7 from any lower value.

When a request is accepted, the block raises a one-cycle pulse together with the accepted level. It loads the mask with that level and clears the master bit. Software writes the register to lower or raise the mask, or to set the master bit after the handler has run. Vector fetch, acknowledge cycles and stacking are handled elsewhere.

Top module: `sr_irq_gate`

## Requirements
- R1: After reset the register reads 16'h0700: mask 7, master bit 0. No take pulse is given until the first clock edge after reset.
- R2: A request level in 1..6 is accepted when it is strictly greater than the mask (register bits 10:8) at the sampling edge. It is not accepted when it is equal to or below the mask.
- R3: Level 7 is accepted, whatever the mask, on the first edge at which the level is 7 after an edge at which it was below 7. The reset state counts as below 7. A level held at 7 is not accepted again.
- R4: Request level 0 never produces a take pulse.
- R5: An accepted request sets take_irq high for exactly the one cycle after the sampling edge, with take_level equal to the accepted level. In that same cycle the register shows mask = accepted level and master bit (bit 12) = 0.
- R6: A software write with no accepted request loads the mask from write bits 10:8 and the master bit from write bit 12. Every other readback bit (15:13, 11, 7:0) is 0 whatever was written.
- R7: When a request is accepted at the same edge as a software write, the write is discarded and the acceptance update of R5 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_level | input | 3 | Encoded request level, 0 = none |
| sr_wr_en | input | 1 | Software write strobe for the status register |
| sr_wr_data | input | 16 | Status register write value |
| sr_rd_data | output | 16 | Status register readback |
| take_irq | output | 1 | One-cycle pulse: interrupt accepted |
| take_level | output | 3 | Level of the accepted interrupt |

## Verification
The bench goes after the mask boundary, where a request equal to the mask must be blocked. A design that compares with greater-or-equal would take the same level repeatedly. It holds level 7 for many cycles and moves it between 6 and 7. A level-sensitive top level would pulse every cycle, and a design that masks level 7 would never pulse once the mask reaches 7. It also collides software writes with acceptances and writes all-ones values. A design that lets the write win would leave a stale mask, and one that stores reserved bits would show them on readback.

// File: rtl/sr_irq_gate.sv
module sr_irq_gate #(
  parameter int SR_W       = 16,
  parameter int LVL_W      = 3,
  parameter int MASK_LSB   = 8,
  parameter int MASTER_BIT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] irq_level,
  input  logic             sr_wr_en,
  input  logic [SR_W-1:0]  sr_wr_data,
  output logic [SR_W-1:0]  sr_rd_data,
  output logic             take_irq,
  output logic [LVL_W-1:0] take_level
);
  localparam logic [LVL_W-1:0] NMI_LVL  = '1;
  localparam logic [LVL_W-1:0] NONE_LVL = '0;

  logic [LVL_W-1:0] mask_q;
  logic             master_q;
  logic             was_top_q;

  wire at_top    = (irq_level == NMI_LVL);
  wire top_edge  = at_top && !was_top_q;
  wire maskable  = (irq_level != NONE_LVL) && !at_top && (irq_level > mask_q);
  wire accept    = top_edge || maskable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= NMI_LVL;
      master_q   <= 1'b0;
      was_top_q  <= 1'b0;
      take_irq   <= 1'b0;
      take_level <= NONE_LVL;
    end else begin
      was_top_q <= at_top;
      take_irq  <= accept;
      if (accept) begin
        take_level <= irq_level;
        mask_q     <= irq_level;
        master_q   <= 1'b0;
      end else if (sr_wr_en) begin
        mask_q   <= sr_wr_data[MASK_LSB +: LVL_W];
        master_q <= sr_wr_data[MASTER_BIT];
      end
    end
  end

  always_comb begin
    sr_rd_data = '0;
    sr_rd_data[MASK_LSB +: LVL_W] = mask_q;
    sr_rd_data[MASTER_BIT]        = master_q;
  end
endmodule

// File: rtl/sr_irq_gate_chk.sv
module sr_irq_gate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  irq_level,
  input logic [15:0] sr_rd_data,
  input logic        take_irq,
  input logic [2:0]  take_level
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  AST_LVL0_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> take_level != 3'd0); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_rd_data & 16'hE8FF) == 16'h0000); // R6
  AST_TAKE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> (sr_rd_data[10:8] == take_level) && !sr_rd_data[12]); // R5
  AST_MASK_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != 3'd0 && irq_level != 3'd7 && irq_level <= sr_rd_data[10:8]) |=> !take_irq); // R2
  AST_TOP_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(irq_level) == 3'd7 && irq_level == 3'd7) |=> !take_irq); // R3
endmodule

bind sr_irq_gate sr_irq_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .sr_rd_data(sr_rd_data),
  .take_irq(take_irq), .take_level(take_level)
);

// File: tb/sr_irq_gate_tb.sv
module sr_irq_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  irq_level = 3'd0;
  logic        sr_wr_en = 1'b0;
  logic [15:0] sr_wr_data = 16'h0;
  logic [15:0] sr_rd_data;
  logic        take_irq;
  logic [2:0]  take_level;

  int n_run = 0, n_fail = 0;
  logic [2:0] m_mask = 3'd7;
  logic       m_master = 1'b0;
  logic       m_prev7 = 1'b0;
  logic [2:0] m_tlvl = 3'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sr_irq_gate u_dut (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .sr_wr_en(sr_wr_en),
    .sr_wr_data(sr_wr_data), .sr_rd_data(sr_rd_data),
    .take_irq(take_irq), .take_level(take_level)
  );

  function automatic logic f_accept(input logic [2:0] lvl, input logic [2:0] msk, input logic p7);
    return (lvl == 3'd7 && !p7) || (lvl != 3'd0 && lvl != 3'd7 && lvl > msk);
  endfunction

  function automatic logic [15:0] f_sr(input logic [2:0] msk, input logic mst);
    return {3'b000, mst, 1'b0, msk, 8'h00};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] lvl, input logic we, input logic [15:0] wd, input string tag);
    logic acc;
    @(negedge clk);
    irq_level = lvl; sr_wr_en = we; sr_wr_data = wd;
    acc = f_accept(lvl, m_mask, m_prev7);
    if (acc) begin m_mask = lvl; m_master = 1'b0; m_tlvl = lvl; end
    else if (we) begin m_mask = wd[10:8]; m_master = wd[12]; end
    m_prev7 = (lvl == 3'd7);
    @(posedge clk); #1;
    check({tag, " take"}, {31'd0, take_irq}, {31'd0, acc});
    if (acc) check({tag, " level"}, {29'd0, take_level}, {29'd0, m_tlvl});
    check({tag, " sr"}, {16'd0, sr_rd_data}, {16'd0, f_sr(m_mask, m_master)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset sr", {16'd0, sr_rd_data}, 32'h0700);
    check("R1 reset take", {31'd0, take_irq}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    step(3'd0, 1'b1, 16'h0000, "R6 write mask0");
    step(3'd0, 1'b0, 16'h0, "R4 level0 mask0");
    step(3'd3, 1'b0, 16'h0, "R2 level3 over mask0");
    step(3'd3, 1'b0, 16'h0, "R2 level3 equal mask");
    step(3'd2, 1'b0, 16'h0, "R2 level2 below mask");
    step(3'd4, 1'b0, 16'h0, "R5 level4 taken");
    step(3'd0, 1'b1, 16'hFFFF, "R6 write all ones");
    step(3'd0, 1'b1, 16'h1500, "R6 write master mask5");
    step(3'd6, 1'b0, 16'h0, "R5 level6 clears master");
    for (int i = 0; i < 5; i++) step(3'd7, 1'b0, 16'h0, "R3 level7 held");
    step(3'd6, 1'b0, 16'h0, "R2 level6 blocked by mask7");
    step(3'd7, 1'b0, 16'h0, "R3 level7 re-edge");
    step(3'd0, 1'b1, 16'h1200, "R6 write mask2");
    step(3'd5, 1'b1, 16'h1000, "R7 write collides");
    step(3'd0, 1'b1, 16'h0000, "R6 write mask0");
    step(3'd1, 1'b0, 16'h0, "R2 level1 over mask0");

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] lvl;
      logic we;
      logic [15:0] wd;
      if (i == 0) void'($urandom(32'h5EED));
      lvl = 3'($urandom_range(0, 7));
      we  = ($urandom_range(0, 3) == 0);
      wd  = 16'($urandom());
      if (lvl == 3'd0)      step(lvl, we, wd, "R4 rand");
      else if (lvl == 3'd7) step(lvl, we, wd, "R3 rand");
      else if (we)          step(lvl, we, wd, "R7 rand");
      else                  step(lvl, we, wd, "R2 rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule